// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers up to 31 level-sensitive interrupt lines and drives one interrupt request line into a single processor. Software sets the urgency of each source with a 3-bit priority, picks which sources may compete with a per-source enable bit, and sets a masking threshold. A source that is pending and enabled and whose priority lies strictly above the threshold is eligible. The request line is high while any source is eligible.

The processor services an interrupt in three steps. It reads the claim register, which returns the winning source ID and retires that pending request in the same clock edge. It then services the device. Last, it writes the ID back to the same register to signal completion. Each source has a gateway that holds one request at most. After a claim, the gateway stays closed until a completion naming that source arrives. A completion is not compared with the last claimed ID, but it is dropped when the named source is disabled at that moment.

Top module: `irq_hub`

## Requirements
- R1: After reset every priority, the enable word and the threshold read as 0, no source is pending, `ext_irq` is low and `bus_rdata` is 0.
- R2: Register map, using word addresses on `bus_addr`. Address n (1..31) holds the priority of source n. Address 32 is the enable word, where bit n enables source n and bit 0 always reads 0. Address 33 is the threshold. Address 34 is claim on read and complete on write. Every other address reads 0. Priority and threshold keep only `wdata[2:0]` and read back with the upper bits at zero. Read data shows on `bus_rdata` in the cycle after the `bus_re` pulse.
- R3: A source whose priority is 0 never becomes eligible, whatever its enable bit and level.
- R4: Among eligible sources the highest priority wins. When priorities are equal, the lowest ID wins.
- R5: A source is eligible only when its priority is strictly greater than the threshold. A threshold of 7 masks every source.
- R6: A source whose enable bit is 0 takes no part in arbitration, but its gateway still latches the request. Setting the enable bit later makes the latched request eligible.
- R7: A claim read returns the winning ID, or 0 when nothing is eligible. On that same clock edge it clears the winner's pending bit.
- R8: After a claim, the source's gateway latches no new request until a completion for that source is accepted, even while its input stays high.
- R9: A completion write of ID n to address 34 reopens gateway n when source n is enabled and in service, whatever ID was claimed last. On `src_lvl`, bit k is the line of source k+1.
- R10: A completion that names a disabled source, or an ID outside 1..31, changes nothing.
- R11: `ext_irq` follows eligibility without a clock delay. It is high exactly when a claim read would return a nonzero ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 31 | Level interrupt lines, bit k is source k+1 |
| bus_addr | input | 6 | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a read of address 34 is a claim) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_irq | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the assertions check several properties. The claim pulse reaches only a gateway that is pending, and that gateway's pending bit is clear on the next cycle. A gateway in service stays there until it is given a completion. The winner's priority is above the threshold. `ext_irq` agrees with a nonzero winner. A threshold write lands with only its low bits kept. Other behaviours depend on what software did over many cycles, so only the bench scenarios can show them. These are the lowest-ID tie-break, completions that name an ID other than the last claimed one, completions that are dropped because the source is disabled, and a request that was latched while its source was disabled becoming visible once the source is enabled.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [1:0] {
    GW_IDLE = 2'd0,
    GW_PEND = 2'd1,
    GW_BUSY = 2'd2
  } gw_state_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
  import irq_hub_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o
);
  gw_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GW_IDLE;
    end else begin
      unique case (state_q)
        GW_IDLE: if (lvl_i)   state_q <= GW_PEND;
        GW_PEND: if (claim_i) state_q <= GW_BUSY;
        GW_BUSY: if (done_i)  state_q <= GW_IDLE;
        default:              state_q <= GW_IDLE;
      endcase
    end
  end

  assign pend_o = (state_q == GW_PEND);

  // R7: the arbiter only claims a pending source, and the claim retires it
  p_claim_needs_pend_r7: assert property (@(posedge clk) disable iff (rst)
    claim_i |-> pend_o);
  p_claim_clears_r7: assert property (@(posedge clk) disable iff (rst)
    claim_i |=> !pend_o);
  // R8: in service until a completion arrives
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == GW_BUSY && !done_i) |=> (state_q == GW_BUSY));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
  output logic [NUM_SRC-1:0]               en_o,
  output logic [PRIO_W-1:0]                thr_o
);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(NUM_SRC + 2);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_o[k] <= '0;
      end else if (we_i && addr_i == ADDR_W'(k + 1)) begin
        prio_o[k] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o  <= '0;
      thr_o <= '0;
    end else if (we_i) begin
      if (addr_i == EN_ADDR)  en_o  <= wdata_i[NUM_SRC:1];
      if (addr_i == THR_ADDR) thr_o <= wdata_i[PRIO_W-1:0];
    end
  end

  // R2: a threshold write keeps only its low bits
  p_thr_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == THR_ADDR) |=> (thr_o == $past(wdata_i[PRIO_W-1:0])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                win_id_o,
  output logic                           any_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_elig
    assign elig[k] = pend_i[k] && en_i[k] && (prio_i[k] > thr_i);
  end

  assign any_o = |elig;

  // Scan from the highest ID down; ">=" lets a lower ID take a tie
  always_comb begin
    logic [PRIO_W-1:0] best_p;
    best_p   = '0;
    win_id_o = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (elig[k] && prio_i[k] >= best_p) begin
        best_p   = prio_i[k];
        win_id_o = ID_W'(k + 1);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               ext_irq
);
  localparam int ID_W = $clog2(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(NUM_SRC + 2);
  localparam logic [ADDR_W-1:0] CLM_ADDR = ADDR_W'(NUM_SRC + 3);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
  logic [NUM_SRC-1:0]             en_w;
  logic [PRIO_W-1:0]              thr_w;
  logic [NUM_SRC-1:0]             pend_w;
  logic [NUM_SRC-1:0]             claim_v;
  logic [NUM_SRC-1:0]             done_v;
  logic [ID_W-1:0]                win_id;
  logic                           any_w;
  logic                           claim_hit;
  logic                           done_hit;
  logic [DATA_W-1:0]              rd_val;
  logic [PRIO_W-1:0]              win_prio;

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_cfg (
    .clk(clk), .rst(rst), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .prio_o(prio_w), .en_o(en_w), .thr_o(thr_w)
  );

  assign claim_hit = bus_re && (bus_addr == CLM_ADDR);
  assign done_hit  = bus_we && (bus_addr == CLM_ADDR);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign claim_v[k] = claim_hit && (win_id == ID_W'(k + 1));
    assign done_v[k]  = done_hit && en_w[k] && (bus_wdata == DATA_W'(k + 1));

    irq_gateway i_gw (
      .clk(clk), .rst(rst), .lvl_i(src_lvl[k]),
      .claim_i(claim_v[k]), .done_i(done_v[k]), .pend_o(pend_w[k])
    );
  end

  irq_arbiter #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) i_arb (
    .pend_i(pend_w), .en_i(en_w), .prio_i(prio_w), .thr_i(thr_w),
    .win_id_o(win_id), .any_o(any_w)
  );

  assign ext_irq = any_w;

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (bus_addr == ADDR_W'(k + 1)) rd_val = DATA_W'(prio_w[k]);
    end
    if (bus_addr == EN_ADDR)  rd_val = DATA_W'({en_w, 1'b0});
    if (bus_addr == THR_ADDR) rd_val = DATA_W'(thr_w);
    if (bus_addr == CLM_ADDR) rd_val = DATA_W'(win_id);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= rd_val;
    end
  end

  always_comb begin
    win_prio = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (win_id == ID_W'(k + 1)) win_prio = prio_w[k];
    end
  end

  // R5: a winner always sits above the threshold
  p_win_above_thr_r5: assert property (@(posedge clk) disable iff (rst)
    (win_id != '0) |-> (win_prio > thr_w));
  // R11: request line agrees with what a claim would return
  p_irq_vs_claim_r11: assert property (@(posedge clk) disable iff (rst)
    ext_irq == (win_id != '0));
  // R7: a claim read hands out the winner one cycle later
  p_claim_data_r7: assert property (@(posedge clk) disable iff (rst)
    claim_hit |=> (bus_rdata == DATA_W'($past(win_id))));
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int N = 31;
  localparam int CLM = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src_lvl = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_irq;

  int checks = 0;
  int errors = 0;

  // bench model
  int          mprio [32];
  logic [31:0] men;
  int          mthr;
  int          mst [32];   // 0 idle, 1 pending, 2 in service
  int          exp_rd;

  irq_hub i_irq_hub (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_irq(ext_irq)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_win();
    int bp = 0;
    int w = 0;
    for (int id = N; id >= 1; id--) begin
      if (mst[id] == 1 && men[id] && mprio[id] > mthr && mprio[id] >= bp) begin
        bp = mprio[id];
        w = id;
      end
    end
    return w;
  endfunction

  function automatic int model_read(int a);
    if (a >= 1 && a <= N) return mprio[a];
    if (a == 32) return int'(men);
    if (a == 33) return mthr;
    if (a == CLM) return exp_win();
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      mprio[i] = 0;
      mst[i] = 0;
    end
    men = '0;
    mthr = 0;
  endtask

  // One bus cycle, driven right after a falling edge; returns after the next one
  task automatic cyc(bit we, bit re, int a, int wd, string req);
    int w;
    int old_st [32];
    bus_we = we;
    bus_re = re;
    bus_addr = 6'(a);
    bus_wdata = wd;
    w = exp_win();
    if (re) exp_rd = model_read(a);
    for (int i = 0; i < 32; i++) old_st[i] = mst[i];
    @(negedge clk);
    if (re && a == CLM && w != 0) mst[w] = 2;
    if (we && a == CLM && wd >= 1 && wd <= N && men[wd] && old_st[wd] == 2) mst[wd] = 0;
    for (int id = 1; id <= N; id++)
      if (old_st[id] == 0 && src_lvl[id-1]) mst[id] = 1;
    if (we) begin
      if (a >= 1 && a <= N) mprio[a] = wd & 7;
      if (a == 32) men = wd & 32'hFFFF_FFFE;
      if (a == 33) mthr = wd & 7;
    end
    bus_we = 1'b0;
    bus_re = 1'b0;
    if (re) check(req, int'(bus_rdata), exp_rd);
    check({req, "/R11 irq"}, int'(ext_irq), int'(exp_win() != 0));
  endtask

  task automatic wr(int a, int wd, string req);
    cyc(1'b1, 1'b0, a, wd, req);
  endtask

  task automatic rd(int a, string req);
    cyc(1'b0, 1'b1, a, 0, req);
  endtask

  task automatic idle(string req);
    cyc(1'b0, 1'b0, 0, 0, req);
  endtask

  task automatic claim_expect(int lit, string req);
    rd(CLM, req);
    check({req, " literal"}, int'(bus_rdata), lit);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240613);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", int'(ext_irq), 0);
    check("R1 rdata", int'(bus_rdata), 0);
    for (int a = 1; a <= 34; a++) rd(a, "R1 reset read");

    // R2: map and stored widths
    wr(5, 32'hFF, "R2");
    rd(5, "R2 prio upper bits");
    check("R2 prio literal", int'(bus_rdata), 7);
    wr(32, 32'hFFFF_FFFF, "R2");
    rd(32, "R2 enable bit0");
    check("R2 enable literal", int'(bus_rdata), 32'hFFFF_FFFE);
    wr(33, 32'h1A, "R2");
    rd(33, "R2 threshold");
    check("R2 threshold literal", int'(bus_rdata), 2);
    rd(35, "R2 unmapped");
    rd(0, "R2 address 0");
    wr(32, 0, "R2"); wr(33, 0, "R2"); wr(5, 0, "R2");

    // R3: priority 0 never interrupts
    src_lvl[1] = 1'b1;
    wr(32, 32'h4, "R3");
    idle("R3");
    check("R3 irq", int'(ext_irq), 0);
    claim_expect(0, "R3 claim");

    // R4 / R7: tie broken by lowest ID, claim retires
    wr(3, 4, "R4"); wr(5, 4, "R4");
    src_lvl[2] = 1'b1; src_lvl[4] = 1'b1;
    wr(32, 32'h2C, "R4");
    idle("R4");
    check("R4 irq", int'(ext_irq), 1);
    claim_expect(3, "R4 tie");
    claim_expect(5, "R7 next");
    claim_expect(0, "R7 empty");

    // R8: level still high, gateway closed
    idle("R8"); idle("R8");
    claim_expect(0, "R8 no repend");

    // R9: completion of an ID other than the last claimed
    wr(CLM, 3, "R9");
    idle("R9");
    check("R9 irq", int'(ext_irq), 1);
    claim_expect(3, "R9 reopened");

    // R10: completion of a disabled source is dropped
    wr(32, 32'h0C, "R10");
    wr(CLM, 5, "R10");
    wr(32, 32'h2C, "R10");
    idle("R10");
    claim_expect(0, "R10 ignored");
    wr(CLM, 5, "R10");
    idle("R10");
    claim_expect(5, "R10 accepted once enabled");
    wr(CLM, 40, "R10 out of range");
    idle("R10");

    // R5: threshold masking
    wr(CLM, 3, "R5"); wr(CLM, 5, "R5");
    idle("R5"); idle("R5");
    wr(33, 4, "R5");
    check("R5 thr4 irq", int'(ext_irq), 0);
    claim_expect(0, "R5 masked");
    wr(33, 3, "R5");
    check("R5 thr3 irq", int'(ext_irq), 1);
    wr(33, 7, "R5"); wr(3, 7, "R5");
    check("R5 thr7 irq", int'(ext_irq), 0);
    wr(33, 6, "R5");
    claim_expect(3, "R5 above thr");

    // R6: disabled request latched, visible once enabled
    wr(9, 7, "R6");
    src_lvl[8] = 1'b1;
    idle("R6");
    check("R6 disabled irq", int'(ext_irq), 0);
    wr(32, 32'h22C, "R6");
    check("R6 enabled irq", int'(ext_irq), 1);
    claim_expect(9, "R6 claim");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if ($urandom_range(0, 3) == 0) src_lvl[$urandom_range(0, N-1)] = 1'($urandom_range(0, 1));
      if (op < 30)      rd(CLM, "R7 random claim");
      else if (op < 45) wr(CLM, int'($urandom_range(0, 33)), "R9 random complete");
      else if (op < 60) wr(int'($urandom_range(1, N)), int'($urandom()), "R4 random prio");
      else if (op < 66) wr(32, int'($urandom()) | 32'h0F0F_0F0E, "R6 random enable");
      else if (op < 72) wr(33, int'($urandom_range(0, 7)), "R5 random thr");
      else if (op < 90) rd(int'($urandom_range(0, 40)), "R2 random read");
      else              idle("R8 random idle");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule